// File: doc/BRIEF.md
# Four-Level Address Pin Decoder

This block works out the low half of a serial slave address from two strap pins. Each pin may be tied low, tied high, or wired to the clock line (SCL) or the data line (SDA) of the two-wire bus. It watches both pins next to SCL and SDA during every bus transfer, whichever device the transfer addresses. When the STOP strobe arrives it commits a new class for each pin. The address can therefore be re-strapped without a power cycle.

Straight after reset, before any transfer has run, each pin is classed by its level alone. A pin wired to a bus line reads high at that point because the bus idles high, so the early classification is a pessimistic one. Each pin's class also sets the pull-up enables and the power-up output levels for its own group of ports. The lower pin controls ports 0 to 3 and the upper pin controls ports 4 to 7. The inputs are already-synchronized samples, and the START and STOP strobes come from a bus front end.

Top module: `addr_pin_decoder`

## Requirements
- R1: In the first clock cycle after reset is released, each pin is classed by its level: high gives the supply class and low gives the ground class.
- R2: `addr_lo[1:0]` encodes the lower pin as follows: ground 00, supply 01, SCL 10, SDA 11.
- R3: `addr_lo[3:2]` encodes the upper pin as follows: SCL 00, SDA 01, ground 10, supply 11.
- R4: A pin is classed as SCL when it equalled SCL at every sample from the START cycle up to the cycle before STOP, and it changed value at least once in that window.
- R5: A pin that toggled and did not qualify as SCL is classed as SDA when it equalled SDA at every sample of the same window.
- R6: A pin that held one value through the whole window is classed by that value: 1 gives supply and 0 gives ground.
- R7: A pin that toggled but matched neither bus line keeps its previously committed class.
- R8: The outputs change only in the cycle after a STOP strobe that closes a transfer, or in the seeding cycle. A repeated START restarts the observation window.
- R9: A STOP strobe with no open transfer leaves every output unchanged.
- R10: For each group, `pullup_en` and `power_dflt` are all ones unless that group's pin is classed ground, in which case they are all zeros. Bits 3:0 follow the lower pin and bits 7:4 follow the upper pin.
- R11: Every transfer on the bus re-learns the classes, so a pin that is rewired between transfers is picked up after the next STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pin_lo | input | 1 | Synchronized sample of the lower strap pin |
| pin_hi | input | 1 | Synchronized sample of the upper strap pin |
| scl | input | 1 | Synchronized bus clock line |
| sda | input | 1 | Synchronized bus data line |
| start_stb | input | 1 | One-cycle START (or repeated START) strobe |
| stop_stb | input | 1 | One-cycle STOP strobe |
| addr_lo | output | 4 | Low four slave-address bits |
| pullup_en | output | 2*GRP_W | Per-port pull-up enables |
| power_dflt | output | 2*GRP_W | Per-port power-up output levels |

## Verification
The same byte transfers are run with the pins wired in turn to ground, supply, SCL and SDA, and in swapped roles. Mapping errors show up as wrong codes on one side only, and an SCL/SDA priority mix-up shows up as a swapped class. A pin driven by noise that is unrelated to either bus line checks that an ambiguous class keeps the old value. The remaining cases are a stray STOP with no open transfer and a transfer interrupted by a repeated START. Together they separate the commit rule from a decoder that updates at any STOP or that keeps stale match state. Power-up seeding with a pin wired to SCL checks that the pessimistic high reading is used before the first transfer.

// File: rtl/addr_pin_pkg.sv
package addr_pin_pkg;
   // Connection class of one strap pin
   typedef enum logic [1:0] {
      PC_LOW  = 2'd0,
      PC_HIGH = 2'd1,
      PC_CLK  = 2'd2,
      PC_DAT  = 2'd3
   } pin_class_e;

   localparam int CODE_W = 2;
endpackage

// File: rtl/addr_pin_track.sv
module addr_pin_track
   import addr_pin_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       seed_i,
   input  logic       pin_i,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic       start_i,
   input  logic       stop_i,
   output pin_class_e cls_o
);
   logic       active_q;
   logic       same_clk_q;
   logic       same_dat_q;
   logic       moved_q;
   logic       first_q;
   pin_class_e cls_q;
   pin_class_e cls_next;

   // Decision taken at STOP from the window gathered so far
   always_comb begin
      if (!moved_q)        cls_next = first_q ? PC_HIGH : PC_LOW;
      else if (same_clk_q) cls_next = PC_CLK;
      else if (same_dat_q) cls_next = PC_DAT;
      else                 cls_next = cls_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q   <= 1'b0;
         same_clk_q <= 1'b0;
         same_dat_q <= 1'b0;
         moved_q    <= 1'b0;
         first_q    <= 1'b0;
         cls_q      <= PC_LOW;
      end else if (seed_i) begin
         cls_q <= pin_i ? PC_HIGH : PC_LOW;
      end else if (start_i) begin
         active_q   <= 1'b1;
         same_clk_q <= (pin_i == scl_i);
         same_dat_q <= (pin_i == sda_i);
         moved_q    <= 1'b0;
         first_q    <= pin_i;
      end else if (stop_i) begin
         active_q <= 1'b0;
         if (active_q) cls_q <= cls_next;
      end else if (active_q) begin
         same_clk_q <= same_clk_q & (pin_i == scl_i);
         same_dat_q <= same_dat_q & (pin_i == sda_i);
         moved_q    <= moved_q | (pin_i != first_q);
      end
   end

   assign cls_o = cls_q;
endmodule

// File: rtl/addr_pin_map.sv
module addr_pin_map
   import addr_pin_pkg::*;
#(
   parameter bit UPPER = 1'b0
) (
   input  pin_class_e        cls_i,
   output logic [CODE_W-1:0] code_o,
   output logic              grp_on_o
);
   generate
      if (UPPER) begin : g_upper
         always_comb begin
            case (cls_i)
               PC_CLK:  code_o = 2'b00;
               PC_DAT:  code_o = 2'b01;
               PC_LOW:  code_o = 2'b10;
               default: code_o = 2'b11;
            endcase
         end
      end else begin : g_lower
         always_comb begin
            case (cls_i)
               PC_LOW:  code_o = 2'b00;
               PC_HIGH: code_o = 2'b01;
               PC_CLK:  code_o = 2'b10;
               default: code_o = 2'b11;
            endcase
         end
      end
   endgenerate

   assign grp_on_o = (cls_i != PC_LOW);
endmodule

// File: rtl/addr_pin_decoder.sv
module addr_pin_decoder
   import addr_pin_pkg::*;
#(
   parameter int GRP_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_lo,
   input  logic               pin_hi,
   input  logic               scl,
   input  logic               sda,
   input  logic               start_stb,
   input  logic               stop_stb,
   output logic [3:0]         addr_lo,
   output logic [2*GRP_W-1:0] pullup_en,
   output logic [2*GRP_W-1:0] power_dflt
);
   localparam int NPIN = 2;

   generate
      if (GRP_W < 1) begin : g_bad_grp
         $error("GRP_W must be at least 1");
      end
   endgenerate

   logic            seeded;
   logic [NPIN-1:0] pins;
   logic [NPIN-1:0] grp_on;

   assign pins = {pin_hi, pin_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seeded <= 1'b0;
      else        seeded <= 1'b1;
   end

   generate
      for (genvar g = 0; g < NPIN; g++) begin : g_pin
         pin_class_e cls;

         addr_pin_track u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .seed_i  (!seeded),
            .pin_i   (pins[g]),
            .scl_i   (scl),
            .sda_i   (sda),
            .start_i (start_stb),
            .stop_i  (stop_stb),
            .cls_o   (cls)
         );

         addr_pin_map #(.UPPER(g == 1)) u_map (
            .cls_i    (cls),
            .code_o   (addr_lo[g*CODE_W +: CODE_W]),
            .grp_on_o (grp_on[g])
         );

         assign pullup_en [g*GRP_W +: GRP_W] = {GRP_W{grp_on[g]}};
         assign power_dflt[g*GRP_W +: GRP_W] = {GRP_W{grp_on[g]}};
      end
   endgenerate
endmodule

// File: rtl/addr_pin_decoder_chk.sv
module addr_pin_decoder_chk #(
   parameter int GRP_W = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               stop_stb,
   input logic               seeded,
   input logic [3:0]         addr_lo,
   input logic [2*GRP_W-1:0] pullup_en,
   input logic [2*GRP_W-1:0] power_dflt
);
   // R8: outside seeding and STOP, the address holds
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seeded && !stop_stb) |=> $stable(addr_lo));

   // R10: ground code on the lower pin turns its group off
   p_lo_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_lo[1:0] == 2'b00) |-> (pullup_en[GRP_W-1:0] == '0));

   p_lo_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_lo[1:0] != 2'b00) |-> (pullup_en[GRP_W-1:0] == '1));

   // R10: ground code on the upper pin (10) turns its group off
   p_hi_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_lo[3:2] == 2'b10) |-> (pullup_en[2*GRP_W-1:GRP_W] == '0));

   p_hi_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_lo[3:2] != 2'b10) |-> (pullup_en[2*GRP_W-1:GRP_W] == '1));

   p_dflt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      power_dflt == pullup_en);
endmodule

bind addr_pin_decoder addr_pin_decoder_chk #(.GRP_W(GRP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_stb   (stop_stb),
   .seeded     (seeded),
   .addr_lo    (addr_lo),
   .pullup_en  (pullup_en),
   .power_dflt (power_dflt)
);

// File: tb/sim_addr_pin_decoder.sv
module sim_addr_pin_decoder;
   localparam int CLK_P = 10;
   localparam int GW    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda = 1'b1, start_stb = 1'b0, stop_stb = 1'b0;
   logic noise = 1'b0;
   int   mode_lo = 2, mode_hi = 0;   // 0 gnd, 1 vcc, 2 scl, 3 sda, 4 noise
   logic pin_lo, pin_hi;
   logic [3:0]      addr_lo;
   logic [2*GW-1:0] pullup_en, power_dflt;

   int n_tests = 0, n_fail = 0, cycles = 0;

   function automatic logic pin_of(int m, logic c, logic d, logic n);
      case (m)
         0: return 1'b0;
         1: return 1'b1;
         2: return c;
         3: return d;
         default: return n;
      endcase
   endfunction

   assign pin_lo = pin_of(mode_lo, scl, sda, noise);
   assign pin_hi = pin_of(mode_hi, scl, sda, noise);

   addr_pin_decoder #(.GRP_W(GW)) u0 (
      .clk(clk), .rst_n(rst_n), .pin_lo(pin_lo), .pin_hi(pin_hi),
      .scl(scl), .sda(sda), .start_stb(start_stb), .stop_stb(stop_stb),
      .addr_lo(addr_lo), .pullup_en(pullup_en), .power_dflt(power_dflt));

   always #(CLK_P/2) clk = ~clk;
   always @(negedge clk) noise <= ~noise;

   // Behavioural reference: class per pin, 0 gnd 1 vcc 2 scl 3 sda
   int m_cls[2];
   bit m_act[2], m_sc[2], m_sd[2], m_mv[2], m_first[2];
   bit m_seed;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_seed = 0;
         for (int p = 0; p < 2; p++) begin
            m_cls[p] = 0; m_act[p] = 0; m_sc[p] = 0; m_sd[p] = 0;
            m_mv[p] = 0; m_first[p] = 0;
         end
      end else begin
         for (int p = 0; p < 2; p++) begin
            logic v;
            v = (p == 0) ? pin_lo : pin_hi;
            if (!m_seed) m_cls[p] = v ? 1 : 0;
            else if (start_stb) begin
               m_act[p] = 1; m_sc[p] = (v == scl); m_sd[p] = (v == sda);
               m_mv[p] = 0; m_first[p] = v;
            end else if (stop_stb) begin
               if (m_act[p]) begin
                  if (!m_mv[p]) m_cls[p] = m_first[p] ? 1 : 0;
                  else if (m_sc[p]) m_cls[p] = 2;
                  else if (m_sd[p]) m_cls[p] = 3;
               end
               m_act[p] = 0;
            end else if (m_act[p]) begin
               if (v != scl) m_sc[p] = 0;
               if (v != sda) m_sd[p] = 0;
               if (v != m_first[p]) m_mv[p] = 1;
            end
         end
         m_seed = 1;
      end
   end

   function automatic logic [3:0] exp_addr();
      logic [1:0] lo, hi;
      lo = 2'(m_cls[0]);
      case (m_cls[1])
         0: hi = 2'b10;
         1: hi = 2'b11;
         2: hi = 2'b00;
         default: hi = 2'b01;
      endcase
      return {hi, lo};
   endfunction

   function automatic logic [2*GW-1:0] exp_pull();
      return {{GW{m_cls[1] != 0}}, {GW{m_cls[0] != 0}}};
   endfunction

   // Per-cycle comparison (R8 timing is covered by comparing every clock)
   always @(posedge clk) begin
      #(CLK_P/4);
      if (rst_n) begin
         n_tests++;
         if (addr_lo[1:0] !== exp_addr() [1:0]) begin
            n_fail++;
            $display("FAIL R2 cycle %0d: addr_lo[1:0]=%b expected %b", cycles, addr_lo[1:0], exp_addr() [1:0]);
         end
         n_tests++;
         if (addr_lo[3:2] !== exp_addr() [3:2]) begin
            n_fail++;
            $display("FAIL R3 cycle %0d: addr_lo[3:2]=%b expected %b", cycles, addr_lo[3:2], exp_addr() [3:2]);
         end
         n_tests++;
         if (pullup_en !== exp_pull() || power_dflt !== exp_pull()) begin
            n_fail++;
            $display("FAIL R10 cycle %0d: pull=%h dflt=%h expected %h", cycles, pullup_en, power_dflt, exp_pull());
         end
      end
   end

   task automatic step(int n = 1);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(string tag, logic [3:0] ea, logic [2*GW-1:0] ep);
      n_tests++;
      if (addr_lo !== ea || pullup_en !== ep) begin
         n_fail++;
         $display("FAIL %s: addr=%h pull=%h expected addr=%h pull=%h", tag, addr_lo, pullup_en, ea, ep);
      end
   endtask

   task automatic bus_start();
      sda = 1'b0; start_stb = 1'b1; step();
      start_stb = 1'b0;
   endtask

   task automatic bus_rstart();
      scl = 1'b0; step(); sda = 1'b1; step(); scl = 1'b1; step();
      bus_start();
   endtask

   task automatic bus_bit(logic b);
      scl = 1'b0; step(); sda = b; step(); scl = 1'b1; step(2);
   endtask

   task automatic bus_byte(logic [7:0] d);
      for (int i = 7; i >= 0; i--) bus_bit(d[i]);
      bus_bit(1'b0);
   endtask

   task automatic bus_stop();
      scl = 1'b0; step(); sda = 1'b0; step(); scl = 1'b1; step();
      sda = 1'b1; stop_stb = 1'b1; step();
      stop_stb = 1'b0; step(3);
   endtask

   task automatic txn(logic [7:0] d);
      bus_start(); bus_byte(d); bus_byte(~d); bus_stop();
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(3);
      // R1: lower pin on SCL reads high (vcc 01), upper on ground (10)
      chk("R1 seed", 4'b1001, 8'h0F);

      txn(8'hA5);   // R4: lower follows SCL -> 10; upper ground -> 10
      chk("R4 lo=scl", 4'b1010, 8'h0F);

      mode_lo = 3; mode_hi = 1;
      step(2);
      chk("R8 no change before transfer", 4'b1010, 8'h0F);
      txn(8'h3C);   // R5: lower SDA -> 11; R6: upper vcc -> 11
      chk("R5 lo=sda hi=vcc", 4'b1111, 8'hFF);

      mode_lo = 0; mode_hi = 2;
      txn(8'h96);   // R6 lower gnd -> 00; R3 upper scl -> 00; R11 relearned
      chk("R11 lo=gnd hi=scl", 4'b0000, 8'hF0);

      mode_lo = 4; mode_hi = 3;
      txn(8'h5A);   // R7: noise keeps gnd; upper sda -> 01
      chk("R7 noise keeps class", 4'b0100, 8'hF0);

      mode_lo = 1; mode_hi = 0;
      step(2);
      stop_stb = 1'b1; step(); stop_stb = 1'b0; step(3);
      chk("R9 stray stop", 4'b0100, 8'hF0);

      // R8: repeated START restarts the window; noise before it is forgotten
      mode_lo = 4;
      bus_start(); bus_byte(8'hC3);
      mode_lo = 1;
      bus_rstart(); bus_byte(8'h81); bus_stop();
      chk("R8 repeated start", 4'b1001, 8'h0F);

      mode_lo = 2; mode_hi = 3;
      txn(8'h00);
      chk("R2 lo=scl R3 hi=sda", 4'b0110, 8'hFF);

      step(4);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule